// File: doc/BRIEF.md
# PCM time-slot transmitter with synchronized start

This block drives the transmit data line of a time-division PCM link. Everything runs on the serial bit clock of the link. An external slot sync input marks the active slot. The block puts out one byte per active slot, most significant bit first, and holds the line at logic 1 everywhere else.

Two conditions arm the transmitter: PCM mode must be selected, and the transmit enable must be high. From that point it counts a fixed warm-up interval, 36 bit clocks by default. When the count completes, it raises its request-to-send output. The next rising edge of the slot sync then starts the sequence. That slot still carries one all-ones byte. Queued bytes follow after it, one per slot, taken from a valid/ready byte input. The delay from the enable to the first data byte is therefore fixed by the slot grid. It does not depend on when in the grid the enable arrived.

Any slot with no real data to send carries the all-ones idle byte. Once data has started, a missing byte also raises a one-cycle underrun flag. A parameter selects the request-to-send variant: plain active-high, or an inverted variant that drops as soon as PCM mode is selected and rises again when the transmitter is ready.

Top module: `pcm_slot_tx`

## Requirements
- R1: While `rst_n` is low and on the cycle after it is released, `tx_line` is 1, `in_ready` is 0 and `underrun` is 0. `rts` is 0 in the default variant and 1 in the inverted variant while `pcm_mode` is 0.
- R2: The transmitter is armed when `tx_en` and `pcm_mode` are both sampled high. Counting from the first rising clock edge that samples it armed, the transmitter becomes ready after exactly WARMUP (default 36) edges and not before.
- R3: With RTS_INVERT=0, `rts` is 1 exactly when the transmitter is ready. With RTS_INVERT=1, `rts` is 1 while `pcm_mode` is 0, goes to 0 combinationally as soon as `pcm_mode` is 1, and is 1 again once the transmitter is ready.
- R4: A slot starts at a rising clock edge that samples `slot_sync` at 1 when the previous edge sampled it at 0. A sync that stays high does not start a new slot.
- R5: For a slot starting at edge E, `tx_line` after edge E+i carries bit [7-i] of that slot's byte for i = 0 to 7, as long as `slot_sync` is still sampled high. After the eighth bit, and whenever `slot_sync` is sampled low, the line is 1. A slot shorter than 8 bits truncates the byte.
- R6: Every slot that starts while the transmitter is not ready carries 0xFF.
- R7: The first slot that starts after the transmitter is ready carries 0xFF. Each following slot carries the next byte accepted from the data input, in the order offered.
- R8: A slot in the data phase that starts with no valid byte, before any data byte has gone out, carries 0xFF and does not raise `underrun`.
- R9: A slot in the data phase that starts with no valid byte, after at least one data byte has gone out, carries 0xFF. `underrun` is then high for exactly the one cycle after that slot's starting edge.
- R10: `in_ready` is high only in the cycle that ends with a slot-starting edge, and only in the data phase. A byte is accepted at that edge when `in_valid` is also high. `in_ready` is 0 at every other time within a slot.
- R11: Sampling `tx_en` low disarms the transmitter at once: `rts` falls after that edge, and later slots carry 0xFF. Arming again takes a full new WARMUP count.
- R12: Raising `tx_en` in the middle of a slot gives the same start sequence as raising it between slots (one 0xFF slot, then data), provided WARMUP edges pass before the next slot starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock; all state updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| pcm_mode | input | 1 | Selects PCM mode; required for arming |
| tx_en | input | 1 | Transmit enable from software |
| slot_sync | input | 1 | High during the active time slot |
| in_valid | input | 1 | A byte is offered on in_data |
| in_data | input | BYTE_W | Offered data byte |
| in_ready | output | 1 | The byte is taken at this clock edge if in_valid is high |
| tx_line | output | 1 | Serial transmit data line, idle 1 |
| rts | output | 1 | Request to send; polarity set by RTS_INVERT |
| underrun | output | 1 | One-cycle pulse: a data-phase slot found no byte |

## Verification
The embedded assertions check four things on every cycle. The line is high after any edge that samples the sync low. The ready state rises only when the warm-up count reaches its end, and it clears as soon as the transmitter is disarmed. `in_ready` and `underrun` never last longer than one cycle, and an underrun only occurs once data has started. Only the bench's scenarios can show the rest: the exact byte carried by each slot, the exact warm-up length, the start sequence being the same for an enable between slots and one inside a slot, truncation of a short slot, and both variants of request-to-send.

// File: rtl/pcm_tx_pkg.sv
`timescale 1ns/1ps
// Shared types for the PCM slot transmitter.
// Assumes: only the two start phases below are needed once armed.
package pcm_tx_pkg;
    // Phase of an armed transmitter: waiting for the lead slot, or sending data
    typedef enum logic {
        PH_WAIT = 1'b0,
        PH_DATA = 1'b1
    } pcm_phase_e;
endpackage

// File: rtl/pcm_tx_warmup.sv
`timescale 1ns/1ps
// Warm-up counter. It counts bit clocks while armed and flags ready when the
// count reaches WARMUP. It clears as soon as the transmitter is disarmed.
// Assumes: WARMUP >= 1.
module pcm_tx_warmup #(
    parameter int WARMUP = 36
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    output logic ready
);
    localparam int CNT_W = $clog2(WARMUP + 1);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(WARMUP);

    logic [CNT_W-1:0] cnt;

    // Count armed edges up to WARMUP and hold there; clear when disarmed
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!arm)
            cnt <= '0;
        else if (cnt != CNT_END)
            cnt <= cnt + 1'b1;
    end

    assign ready = (cnt == CNT_END);

    // R2
    ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready) |-> ($past(cnt) == CNT_W'(WARMUP - 1)));

    // R11
    disarm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !arm |=> !ready);
endmodule

// File: rtl/pcm_tx_slot_seq.sv
`timescale 1ns/1ps
// Slot sequencer. It detects rising slot sync and tracks the start phase. At
// each slot start it picks the byte to send: a lead 0xFF, a data byte, or a
// 0xFF fill with an underrun pulse.
// Assumes: bytes are taken only at slot starts, so a byte never spans slots.
module pcm_tx_slot_seq
    import pcm_tx_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              ready,
    input  logic              slot_sync,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              slot_start,
    output logic [BYTE_W-1:0] slot_byte,
    output logic              underrun
);
    localparam logic [BYTE_W-1:0] FILL = '1;

    logic       sync_prev;
    logic       started;
    pcm_phase_e phase;

    assign slot_start = slot_sync & ~sync_prev;
    assign in_ready   = slot_start & arm & ready & (phase == PH_DATA);
    assign slot_byte  = (in_ready & in_valid) ? in_data : FILL;

    // Keep the previous sync sample for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n)
            sync_prev <= 1'b0;
        else
            sync_prev <= slot_sync;
    end

    // Advance the start phase, note the first data byte, and flag underruns
    always_ff @(posedge clk) begin
        if (!rst_n || !arm) begin
            phase    <= PH_WAIT;
            started  <= 1'b0;
            underrun <= 1'b0;
        end else begin
            underrun <= 1'b0;
            if (slot_start && ready) begin
                if (phase == PH_WAIT) begin
                    phase <= PH_DATA;
                end else if (in_valid) begin
                    started <= 1'b1;
                end else begin
                    underrun <= started;
                end
            end
        end
    end

    // R10
    ready_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |=> !in_ready);

    // R9
    underrun_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |=> !underrun);

    // R8
    underrun_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> started);
endmodule

// File: rtl/pcm_tx_shifter.sv
`timescale 1ns/1ps
// Output shifter. It loads a byte at each slot start and sends it MSB first,
// one bit per clock, while the sync stays high. Otherwise it drives 1.
// Assumes: load only happens while slot_sync is high.
module pcm_tx_shifter #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              slot_sync,
    input  logic              abort,
    output logic              tx_line
);
    localparam int BIT_W = $clog2(BYTE_W + 1);
    localparam logic [BIT_W-1:0] LAST = BIT_W'(BYTE_W - 1);

    logic [BYTE_W-1:0] shreg;
    logic [BIT_W-1:0]  left;

    // Load at slot start, shift while in sync, else idle the line at 1
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg   <= '1;
            left    <= '0;
            tx_line <= 1'b1;
        end else if (load) begin
            tx_line <= load_byte[BYTE_W-1];
            shreg   <= {load_byte[BYTE_W-2:0], 1'b1};
            left    <= LAST;
        end else if (slot_sync && !abort && left != '0) begin
            tx_line <= shreg[BYTE_W-1];
            shreg   <= {shreg[BYTE_W-2:0], 1'b1};
            left    <= left - 1'b1;
        end else begin
            tx_line <= 1'b1;
            left    <= '0;
        end
    end

    // R5
    idle_outside_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_sync |=> tx_line);
endmodule

// File: rtl/pcm_slot_tx.sv
`timescale 1ns/1ps
// PCM time-slot transmitter with synchronized start. Top level: arming,
// warm-up, slot sequencing, serial output and request-to-send polarity.
// Assumes: clk is the serial bit clock, and slot_sync and inputs are
// synchronous to it.
module pcm_slot_tx #(
    parameter int BYTE_W     = 8,
    parameter int WARMUP     = 36,
    parameter bit RTS_INVERT = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pcm_mode,
    input  logic              tx_en,
    input  logic              slot_sync,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    output logic              in_ready,
    output logic              tx_line,
    output logic              rts,
    output logic              underrun
);
    logic arm;
    logic ready;
    logic slot_start;
    logic [BYTE_W-1:0] slot_byte;

    assign arm = tx_en & pcm_mode;

    pcm_tx_warmup #(.WARMUP(WARMUP)) u_warmup (
        .clk   (clk),
        .rst_n (rst_n),
        .arm   (arm),
        .ready (ready)
    );

    pcm_tx_slot_seq #(.BYTE_W(BYTE_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (arm),
        .ready      (ready),
        .slot_sync  (slot_sync),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .slot_start (slot_start),
        .slot_byte  (slot_byte),
        .underrun   (underrun)
    );

    pcm_tx_shifter #(.BYTE_W(BYTE_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (slot_start),
        .load_byte (slot_byte),
        .slot_sync (slot_sync),
        .abort     (~arm),
        .tx_line   (tx_line)
    );

    // Pick the request-to-send variant
    generate
        if (RTS_INVERT) begin : g_rts_inv
            assign rts = ~pcm_mode | ready;
        end else begin : g_rts_pos
            assign rts = ready;
        end
    endgenerate

    // R3
    rts_tracks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_mode && $rose(rts)) |-> $past(arm));
endmodule

// File: tb/test_pcm_slot_tx.sv
`timescale 1ns/1ps
module test_pcm_slot_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pcm_mode = 1'b0;
    logic       tx_en = 1'b0;
    logic       slot_sync = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_ready, tx_line, rts, underrun;
    logic       in_ready_b, tx_line_b, rts_b, underrun_b;

    int total = 0;
    int bad = 0;
    bit done = 0;
    logic [7:0] exp_q[$];
    logic [7:0] src_q[$];

    always #2.5 clk = ~clk;

    pcm_slot_tx i_pcm_slot_tx (
        .clk(clk), .rst_n(rst_n), .pcm_mode(pcm_mode), .tx_en(tx_en),
        .slot_sync(slot_sync), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .tx_line(tx_line), .rts(rts), .underrun(underrun));

    pcm_slot_tx #(.RTS_INVERT(1'b1)) i_pcm_slot_tx_inv (
        .clk(clk), .rst_n(rst_n), .pcm_mode(pcm_mode), .tx_en(tx_en),
        .slot_sync(slot_sync), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready_b), .tx_line(tx_line_b), .rts(rts_b), .underrun(underrun_b));

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Monitor for one slot: pops the expected byte and compares the line bits
    task automatic run_slot(input int len, input int gap, input bit exp_rdy,
                            input bit exp_under, input int en_at, input string tag);
        logic [15:0] got = '0;
        logic [15:0] expv = '0;
        logic [7:0]  eb;
        bit          rdy;
        eb = exp_q.pop_front();
        in_valid = (src_q.size() > 0);
        in_data  = in_valid ? src_q[0] : 8'h00;
        slot_sync = 1'b1;
        #1;
        rdy = in_ready;
        check(rdy == exp_rdy, "R10 in_ready at slot start", int'(rdy), int'(exp_rdy));
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (i == 0) begin
                check(underrun == exp_under, "R9 underrun at slot start", int'(underrun), int'(exp_under));
                if (rdy && in_valid) void'(src_q.pop_front());
                in_valid = 1'b0;
            end
            if (i == 1) begin
                check(underrun == 1'b0, "R9 underrun one cycle", int'(underrun), 0);
                check(in_ready == 1'b0, "R10 in_ready mid slot", int'(in_ready), 0);
            end
            if (i == en_at) tx_en = 1'b1;
            got  = {got[14:0], tx_line};
            expv = {expv[14:0], (i < 8) ? eb[7-i] : 1'b1};
        end
        check(got == expv, tag, int'(got), int'(expv));
        slot_sync = 1'b0;
        repeat (gap) @(negedge clk);
    endtask

    task automatic warmup_check(input string tag);
        tx_en = 1'b1;
        repeat (35) @(negedge clk);
        check(rts == 1'b0, {tag, " rts before 36"}, int'(rts), 0);
        check(rts_b == 1'b0, "R3 inverted rts before ready", int'(rts_b), 0);
        @(negedge clk);
        check(rts == 1'b1, {tag, " rts at 36"}, int'(rts), 1);
        check(rts_b == 1'b1, "R3 inverted rts at ready", int'(rts_b), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check(tx_line == 1'b1, "R1 tx_line in reset", int'(tx_line), 1);
        check(rts == 1'b0, "R1 rts in reset", int'(rts), 0);
        check(rts_b == 1'b1, "R1 inverted rts in reset", int'(rts_b), 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_line == 1'b1 && in_ready == 1'b0 && underrun == 1'b0,
              "R1 outputs after reset", int'({tx_line, in_ready, underrun}), 4);

        // R6: not armed, slot carries FF
        exp_q.push_back(8'hFF);
        run_slot(9, 2, 1'b0, 1'b0, -1, "R6 idle slot");

        // R3: inverted variant drops as soon as PCM mode is selected
        pcm_mode = 1'b1;
        #1;
        check(rts_b == 1'b0, "R3 inverted rts on pcm select", int'(rts_b), 0);
        check(rts == 1'b0, "R3 rts not ready", int'(rts), 0);
        @(negedge clk);

        // R2: exact warm-up
        warmup_check("R2");

        // R7, R4, R5, R9: lead FF, then data in order, then underrun
        src_q = '{8'hA5, 8'h3C, 8'h81};
        exp_q = '{8'hFF, 8'hA5, 8'h3C, 8'h81, 8'hFF};
        run_slot(9, 1, 1'b0, 1'b0, -1, "R7 lead FF slot");
        run_slot(9, 1, 1'b1, 1'b0, -1, "R7 data A5");
        run_slot(8, 3, 1'b1, 1'b0, -1, "R4 data 3C after 1-cycle gap");
        run_slot(8, 1, 1'b1, 1'b0, -1, "R7 data 81");
        run_slot(10, 2, 1'b1, 1'b1, -1, "R9 underrun FF");

        // R11: disarm, rts falls, slot idles
        tx_en = 1'b0;
        @(negedge clk);
        check(rts == 1'b0, "R11 rts after disable", int'(rts), 0);
        src_q = '{8'h77};
        exp_q = '{8'hFF};
        run_slot(9, 2, 1'b0, 1'b0, -1, "R11 idle after disable");
        src_q.delete();

        // R12: enable raised inside a slot, same start sequence
        exp_q = '{8'hFF, 8'hFF, 8'hFF};
        run_slot(10, 40, 1'b0, 1'b0, 3, "R12 enable mid slot FF");
        check(rts == 1'b1, "R12 rts before next sync", int'(rts), 1);
        run_slot(9, 1, 1'b0, 1'b0, -1, "R12 lead FF slot");
        run_slot(9, 1, 1'b1, 1'b0, -1, "R8 no data yet FF");
        src_q = '{8'h5A, 8'hC3};
        exp_q = '{8'h5A, 8'hC3, 8'hFF};
        run_slot(9, 1, 1'b1, 1'b0, -1, "R12 data 5A");
        run_slot(4, 2, 1'b1, 1'b0, -1, "R5 truncated C3");
        run_slot(12, 2, 1'b1, 1'b1, -1, "R5 long slot tail ones");

        // R11: re-arm needs the full count again
        tx_en = 1'b0;
        @(negedge clk);
        warmup_check("R11 rearm");

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule